// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects an internal requester to an external asynchronous SRAM or flash device. The requester presents a single access through a valid/ready request port. The access carries a region number, a direction, an address and write data. The controller then sequences the external chip select, output enable, write enable, address and data-drive signals through setup, strobe and hold phases. The number of cycles in each phase comes from the configuration word of the selected region. There are three regions, and each has its own configuration word. A turnaround gap is inserted between accesses that change direction or region.

The strobe phase can be stretched by an external wait pin. The active level of that pin is selectable, and the stretch is bounded by a programmable cycle limit. If the wait is still active when the limit is reached, the access is cut short and a timeout flag is raised. A rising edge on the wait pin raises a second flag. Both flags pass through an enable mask that is set and cleared by pulses. Each flag is cleared by writing a one to it. All configuration arrives as plain parallel inputs.

Back-pressure rules: the requester raises `req_valid` and holds the direction, region, address and write data stable until it sees `req_ready`. `req_ready` is a one-cycle pulse that marks completion. In that same cycle `rsp_rdata` and `rsp_timeout` are valid. A request still presented during the ready cycle is not taken as a new access. The requester drops valid or changes the fields after the ready cycle.

Top module: `xmem_async_ctrl`

## Requirements
- R1: `req_ready` is high for exactly one cycle per access, at completion. While it is high the controller starts no new access, and the cycle after it has all chip selects high.
- R2: A read to region r drives `mem_cs_n[r]` low and no other chip select. The phases last read-setup+1 cycles (word bits 12:9), then read-strobe+1 cycles with `mem_oe_n` low (bits 8:3), then read-hold+1 cycles (bits 2:0). The strobe-select bit is 0, so the chip select stays low across all three phases.
- R3: A write uses write-setup (bits 25:22), write-strobe (bits 21:16) and write-hold (bits 15:13) in the same way, with `mem_we_n` low for the strobe cycles. `mem_dout` carries the write data during the strobe.
- R4: Turnaround (bits 27:26 of the new access's word) adds turnaround+1 idle cycles before setup, with every chip select high. It is added only when the direction or the region differs from the previous access. The first access after reset has no turnaround.
- R5: With bit 31 of the word set, the chip select is low only during the strobe cycles. With it clear, the chip select spans setup to hold.
- R6: Width field bits 29:28 set the data width: 0 gives 8 bits (mask 0xFF), 1 gives 16 bits (0xFFFF), 2 gives 32 bits. The mask applies to both the captured read data and `mem_dout`.
- R7: With extended wait (bit 30) set, the strobe is held after its programmed length for as long as the synchronized wait is active. `wait_pol` 1 makes a high pin active and 0 makes a low pin active. The pin passes through a two-flop synchronizer. After the pin is released, the strobe ends two cycles later and hold follows.
- R8: With bit 30 clear, the wait pin has no effect on timing or on the timeout flag.
- R9: The timeout case is when the wait is still active after `max_wait` extension cycles. In that case the access ends at that point without a hold phase. Read data is captured there, `rsp_timeout` is 1 with `req_ready`, and timeout flag bit 0 is set.
- R10: A rising edge on the synchronized wait pin sets flag bit 1.
- R11: The mask bits are set by `irq_mask_set` pulses and cleared by `irq_mask_clr` pulses. `irq_status` is the raw flags ANDed with the mask, and `irq` is the OR of `irq_status`.
- R12: A pulse on `irq_clr` bit i clears raw flag i. If a flag event happens in the same cycle, the event wins.
- R13: `mem_oe_n` and `mem_we_n` are never low together, and the data bus is never driven while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_r0 | input | 32 | Region 0 configuration word |
| cfg_r1 | input | 32 | Region 1 configuration word |
| cfg_r2 | input | 32 | Region 2 configuration word |
| wait_pol | input | 1 | Wait active level: 1 high, 0 low |
| max_wait | input | 8 | Maximum extension cycles |
| irq_mask_set | input | 2 | Pulse: enable flag bits |
| irq_mask_clr | input | 2 | Pulse: disable flag bits |
| irq_clr | input | 2 | Pulse: clear raw flag bits (bit0 timeout, bit1 wait rise) |
| irq_status | output | 2 | Masked flags |
| irq | output | 1 | OR of masked flags |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Completion pulse |
| req_write | input | 1 | 1 write, 0 read |
| req_region | input | 2 | Region 0..2 |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| rsp_timeout | output | 1 | Access ended by timeout, valid with req_ready |
| mem_cs_n | output | 3 | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | 32 | External write data |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 32 | External read data |
| mem_wait | input | 1 | External wait pin |

## Verification
The checker watches the following on every cycle:
- at most one chip select is low;
- the two strobes are exclusive, and the bus is not driven during a read strobe;
- every strobe sits inside an asserted chip select;
- `req_ready` never lasts two cycles;
- masked status never shows a disabled flag;
- no strobe runs longer than the programmed maximum plus the wait limit.

Only the bench scenarios can show the exact phase lengths, when turnaround is or is not inserted, the width masking of data, the cycle at which a released wait ends the strobe, and the timeout cut-off with its flag.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int SETUP_W  = 4;
  localparam int STROBE_W = 6;
  localparam int HOLD_W   = 3;
  localparam int TURN_W   = 2;
  localparam int CNT_W    = (STROBE_W > SETUP_W) ? STROBE_W : SETUP_W;
  localparam int REGIONS  = 3;
  localparam int REG_W    = $clog2(REGIONS);
  localparam int WAIT_W   = 8;
  localparam int DATA_W   = 32;
  localparam int IRQ_N    = 2;
  localparam int IRQ_TMO  = 0;
  localparam int IRQ_RISE = 1;

  // Bit 31 first: the packed layout fixes the field positions of the word.
  typedef struct packed {
    logic                sel_strobe;
    logic                ext_wait;
    logic [1:0]          width;
    logic [TURN_W-1:0]   turn;
    logic [SETUP_W-1:0]  wr_setup;
    logic [STROBE_W-1:0] wr_strobe;
    logic [HOLD_W-1:0]   wr_hold;
    logic [SETUP_W-1:0]  rd_setup;
    logic [STROBE_W-1:0] rd_strobe;
    logic [HOLD_W-1:0]   rd_hold;
  } region_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD
  } phase_e;

  function automatic logic [CNT_W-1:0] lead_cnt(region_cfg_t c, logic wr);
    return wr ? CNT_W'(c.wr_setup) : CNT_W'(c.rd_setup);
  endfunction

  function automatic logic [CNT_W-1:0] body_cnt(region_cfg_t c, logic wr);
    return wr ? CNT_W'(c.wr_strobe) : CNT_W'(c.rd_strobe);
  endfunction

  function automatic logic [CNT_W-1:0] tail_cnt(region_cfg_t c, logic wr);
    return wr ? CNT_W'(c.wr_hold) : CNT_W'(c.rd_hold);
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(logic [1:0] w);
    case (w)
      2'd0:    return DATA_W'(32'h0000_00FF);
      2'd1:    return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic active,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES:0]   fill_q;
  logic              prev_q;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      fill_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      fill_q <= {fill_q[STAGES-1:0], 1'b1};
      prev_q <= level;
    end
  end

  assign level  = sync_q[STAGES-1];
  assign active = pol ? level : ~level;
  // Edges are only trusted once the synchronizer holds real pin samples.
  assign rise   = fill_q[STAGES] & level & ~prev_q;
endmodule

// File: rtl/xmem_irq.sv
module xmem_irq
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] evt,
  input  logic [IRQ_N-1:0] clr,
  input  logic [IRQ_N-1:0] mask_set,
  input  logic [IRQ_N-1:0] mask_clr,
  output logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] status,
  output logic             irq
);
  logic [IRQ_N-1:0] raw_q;
  logic [IRQ_N-1:0] mask_q;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        raw_q[i]  <= evt[i] | (raw_q[i] & ~clr[i]);
        mask_q[i] <= mask_set[i] | (mask_q[i] & ~mask_clr[i]);
      end
    end
  end

  assign mask   = mask_q;
  assign status = raw_q & mask_q;
  assign irq    = |status;
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  region_cfg_t [REGIONS-1:0]  cfg_tab,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [REG_W-1:0]           req_region,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       req_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       rsp_timeout,
  input  logic                       wait_act,
  input  logic [WAIT_W-1:0]          max_wait,
  output logic                       tmo_evt,
  output logic [REGIONS-1:0]         mem_cs_n,
  output logic                       mem_oe_n,
  output logic                       mem_we_n,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_dout,
  output logic                       mem_dout_en,
  input  logic [DATA_W-1:0]          mem_din
);
  phase_e             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WAIT_W-1:0]  wcnt_q;
  logic [REG_W-1:0]   reg_q;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  region_cfg_t        cfg_q;
  logic               prev_ok_q;
  logic               done_q;
  logic               tmo_q;
  logic               tmo_evt_q;
  logic [DATA_W-1:0]  rdata_q;

  logic [REG_W-1:0]   pick;
  region_cfg_t        new_cfg;
  logic               need_turn;
  logic               cnt_zero;
  logic [DATA_W-1:0]  cap;
  logic               span;
  logic               cs_on;

  assign pick      = (req_region >= REG_W'(REGIONS)) ? REG_W'(REGIONS-1) : req_region;
  assign new_cfg   = cfg_tab[pick];
  assign need_turn = prev_ok_q && ((reg_q != pick) || (wr_q != req_write));
  assign cnt_zero  = (cnt_q == '0);
  assign cap       = mem_din & lane_mask(cfg_q.width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      wcnt_q    <= '0;
      reg_q     <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cfg_q     <= '0;
      prev_ok_q <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      tmo_evt_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q    <= 1'b0;
      tmo_evt_q <= 1'b0;
      case (state_q)
        PH_IDLE: begin
          if (req_valid && !done_q) begin
            reg_q     <= pick;
            wr_q      <= req_write;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            cfg_q     <= new_cfg;
            prev_ok_q <= 1'b1;
            if (need_turn) begin
              state_q <= PH_TURN;
              cnt_q   <= CNT_W'(new_cfg.turn);
            end else begin
              state_q <= PH_SETUP;
              cnt_q   <= lead_cnt(new_cfg, req_write);
            end
          end
        end
        PH_TURN: begin
          if (cnt_zero) begin
            state_q <= PH_SETUP;
            cnt_q   <= lead_cnt(cfg_q, wr_q);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            state_q <= PH_STROBE;
            cnt_q   <= body_cnt(cfg_q, wr_q);
            wcnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (cfg_q.ext_wait && wait_act) begin
            if (wcnt_q == max_wait) begin
              if (!wr_q) rdata_q <= cap;
              tmo_q     <= 1'b1;
              tmo_evt_q <= 1'b1;
              done_q    <= 1'b1;
              state_q   <= PH_IDLE;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end else begin
            if (!wr_q) rdata_q <= cap;
            tmo_q   <= 1'b0;
            state_q <= PH_HOLD;
            cnt_q   <= tail_cnt(cfg_q, wr_q);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign span  = (state_q == PH_SETUP) || (state_q == PH_STROBE) || (state_q == PH_HOLD);
  assign cs_on = cfg_q.sel_strobe ? (state_q == PH_STROBE) : span;

  for (genvar i = 0; i < REGIONS; i++) begin : g_cs
    assign mem_cs_n[i] = ~(cs_on && (reg_q == REG_W'(i)));
  end

  assign mem_oe_n    = ~((state_q == PH_STROBE) && !wr_q);
  assign mem_we_n    = ~((state_q == PH_STROBE) && wr_q);
  assign mem_dout_en = span && wr_q;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q & lane_mask(cfg_q.width);
  assign req_ready   = done_q;
  assign rsp_rdata   = rdata_q;
  assign rsp_timeout = tmo_q;
  assign tmo_evt     = tmo_evt_q;
endmodule

// File: rtl/xmem_async_ctrl.sv
module xmem_async_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         cfg_r0,
  input  logic [31:0]         cfg_r1,
  input  logic [31:0]         cfg_r2,
  input  logic                wait_pol,
  input  logic [WAIT_W-1:0]   max_wait,
  input  logic [IRQ_N-1:0]    irq_mask_set,
  input  logic [IRQ_N-1:0]    irq_mask_clr,
  input  logic [IRQ_N-1:0]    irq_clr,
  output logic [IRQ_N-1:0]    irq_status,
  output logic                irq,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [REG_W-1:0]    req_region,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_timeout,
  output logic [REGIONS-1:0]  mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dout,
  output logic                mem_dout_en,
  input  logic [DATA_W-1:0]   mem_din,
  input  logic                mem_wait
);
  region_cfg_t [REGIONS-1:0] cfg_tab;
  logic                      wait_act;
  logic                      wait_rise;
  logic                      tmo_evt;
  logic [IRQ_N-1:0]          irq_evt;
  logic [IRQ_N-1:0]          irq_mask_q;

  assign cfg_tab[0] = region_cfg_t'(cfg_r0);
  assign cfg_tab[1] = region_cfg_t'(cfg_r1);
  assign cfg_tab[2] = region_cfg_t'(cfg_r2);

  xmem_wait_sync #(.STAGES(SYNC_STAGES)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (mem_wait),
    .pol    (wait_pol),
    .active (wait_act),
    .rise   (wait_rise)
  );

  xmem_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_tab     (cfg_tab),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_region  (req_region),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_rdata   (rsp_rdata),
    .rsp_timeout (rsp_timeout),
    .wait_act    (wait_act),
    .max_wait    (max_wait),
    .tmo_evt     (tmo_evt),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mem_din     (mem_din)
  );

  always_comb begin
    irq_evt           = '0;
    irq_evt[IRQ_TMO]  = tmo_evt;
    irq_evt[IRQ_RISE] = wait_rise;
  end

  xmem_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (irq_evt),
    .clr      (irq_clr),
    .mask_set (irq_mask_set),
    .mask_clr (irq_mask_clr),
    .mask     (irq_mask_q),
    .status   (irq_status),
    .irq      (irq)
  );
endmodule

// File: rtl/xmem_async_chk.sv
module xmem_async_chk
  import xmem_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [REGIONS-1:0] mem_cs_n,
  input logic               mem_oe_n,
  input logic               mem_we_n,
  input logic               mem_dout_en,
  input logic               req_ready,
  input logic [IRQ_N-1:0]   irq_status,
  input logic [IRQ_N-1:0]   irq_mask
);
  localparam int RUN_LIMIT = (1 << STROBE_W) + (1 << WAIT_W);
  localparam int RUN_W     = $clog2(RUN_LIMIT + 2);

  logic [RUN_W-1:0] run_q;
  logic             strobing;

  assign strobing = !mem_oe_n || !mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (strobing) run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R13
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en); // R13
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    strobing |-> (mem_cs_n != '1)); // R5
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R1
  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status & ~irq_mask) == '0); // R11
  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RUN_LIMIT)); // R9
endmodule

bind xmem_async_ctrl xmem_async_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_cs_n    (mem_cs_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dout_en (mem_dout_en),
  .req_ready   (req_ready),
  .irq_status  (irq_status),
  .irq_mask    (irq_mask_q)
);

// File: tb/xmem_async_ctrl_bench.sv
module xmem_async_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_r0 = '0, cfg_r1 = '0, cfg_r2 = '0;
  logic        wait_pol = 1'b1;
  logic [7:0]  max_wait = '0;
  logic [1:0]  irq_mask_set = '0, irq_mask_clr = '0, irq_clr = '0;
  logic [1:0]  irq_status;
  logic        irq;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [1:0]  req_region = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_timeout;
  logic [2:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_dout_en;
  logic [15:0] mem_addr;
  logic [31:0] mem_dout;
  logic [31:0] mem_din;
  logic        mem_wait = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic       prev_ok = 1'b0;
  logic [1:0] prev_rg = '0;
  logic       prev_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] din_of(logic [15:0] a);
    return {a[7:0], ~a[7:0], a[15:8], 8'h3C};
  endfunction
  assign mem_din = din_of(mem_addr);

  function automatic logic [31:0] mk_cfg(logic sel, logic ext, logic [1:0] w, logic [1:0] ta,
      logic [3:0] ws, logic [5:0] wst, logic [2:0] wh, logic [3:0] rs, logic [5:0] rst, logic [2:0] rh);
    return {sel, ext, w, ta, ws, wst, wh, rs, rst, rh};
  endfunction

  function automatic logic [31:0] wmask(logic [1:0] w);
    return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  xmem_async_ctrl u_xmem_async_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_r0(cfg_r0), .cfg_r1(cfg_r1), .cfg_r2(cfg_r2),
    .wait_pol(wait_pol), .max_wait(max_wait), .irq_mask_set(irq_mask_set),
    .irq_mask_clr(irq_mask_clr), .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait(mem_wait)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access; samples every cycle at the falling edge until req_ready.
  task automatic run_acc(input logic [1:0] rg, input logic wr, input logic [15:0] ad,
      input logic [31:0] wd, input int rel_at, output int ncyc, output int nstb,
      output int ncs, output logic [2:0] csseen, output logic [31:0] dseen,
      output logic [31:0] rd, output logic tmo, output logic turn);
    turn = prev_ok && (prev_rg != rg || prev_wr != wr);
    prev_ok = 1'b1; prev_rg = rg; prev_wr = wr;
    ncyc = 0; nstb = 0; ncs = 0; csseen = '0; dseen = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_region = rg; req_addr = ad; req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      ncyc++;
      if (!mem_oe_n || !mem_we_n) nstb++;
      if (mem_cs_n != 3'b111) ncs++;
      csseen |= ~mem_cs_n;
      if (!mem_we_n) dseen = mem_dout;
      if (rel_at != 0 && nstb == rel_at) mem_wait = ~wait_pol;
      if (ncyc > 2000) begin
        chk("R1 access watchdog", 32'(ncyc), 32'd0);
        break;
      end
    end
    rd = rsp_rdata; tmo = rsp_timeout;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 ready single cycle", {31'd0, req_ready}, 32'd0);
    chk("R1 idle after ready", {29'd0, mem_cs_n}, 32'd7);
  endtask

  task automatic pulse(input int which, input logic [1:0] v);
    @(negedge clk);
    if (which == 0) irq_mask_set = v; else if (which == 1) irq_mask_clr = v; else irq_clr = v;
    @(negedge clk);
    irq_mask_set = '0; irq_mask_clr = '0; irq_clr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ncyc, nstb, ncs, exp_cyc;
    logic [2:0] csseen;
    logic [31:0] dseen, rd;
    logic tmo, turn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cs", {29'd0, mem_cs_n}, 32'd7);
    chk("R13 reset strobes", {30'd0, mem_oe_n, mem_we_n}, 32'd3);
    chk("R3 reset drive", {31'd0, mem_dout_en}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd0);
    chk("R11 reset irq", {29'd0, irq, irq_status}, 32'd0);

    // Timing sweep over regions 0 and 1, turnaround 2, full width.
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int c = 0; c < 3; c++) begin
          int rs, rst, rh, ws, wst, wh;
          rs = a * 3; rst = b * 5; rh = c * 3;
          ws = rs + 1; wst = rst + 2; wh = rh;
          cfg_r0 = mk_cfg(0, 0, 2, 2, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh));
          cfg_r1 = cfg_r0;
          for (int k = 0; k < 4; k++) begin
            logic [1:0] rg;
            logic wr;
            logic [15:0] ad;
            logic [31:0] wd;
            rg = (k < 2) ? 2'd0 : 2'd1;
            wr = (k >= 2);
            ad = 16'(a * 1000 + b * 97 + c * 13 + k * 5 + 7);
            wd = {ad, ~ad} ^ 32'h1234_5678;
            run_acc(rg, wr, ad, wd, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
            if (!wr) begin
              exp_cyc = (turn ? 3 : 0) + rs + rst + rh + 3;
              chk("R2 R4 read cycles", 32'(ncyc), 32'(exp_cyc));
              chk("R2 read strobe", 32'(nstb), 32'(rst + 1));
              chk("R2 read cs span", 32'(ncs), 32'(rs + rst + rh + 3));
              chk("R2 read data", rd, din_of(ad));
            end else begin
              exp_cyc = (turn ? 3 : 0) + ws + wst + wh + 3;
              chk("R3 R4 write cycles", 32'(ncyc), 32'(exp_cyc));
              chk("R3 write strobe", 32'(nstb), 32'(wst + 1));
              chk("R3 write data", dseen, wd);
            end
            chk("R2 cs select", {29'd0, csseen}, 32'(3'b001 << rg));
            chk("R9 no timeout", {31'd0, tmo}, 32'd0);
          end
        end
      end
    end

    // R5: strobe-select mode on region 1.
    cfg_r1 = mk_cfg(1, 0, 2, 1, 4'd2, 6'd3, 3'd2, 4'd3, 6'd4, 3'd1);
    run_acc(2'd1, 0, 16'h0A0B, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R5 cs only in strobe (read)", 32'(ncs), 32'd5);
    chk("R5 read cycles", 32'(ncyc), 32'((turn ? 2 : 0) + 4 + 5 + 2));
    run_acc(2'd1, 1, 16'h0A0C, 32'hCAFE_F00D, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R5 cs only in strobe (write)", 32'(ncs), 32'd4);

    // R6: width masking on region 0.
    cfg_r0 = mk_cfg(0, 0, 0, 0, 4'd0, 6'd1, 3'd0, 4'd1, 6'd1, 3'd0);
    run_acc(2'd0, 0, 16'hBEEF, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R6 8-bit read", rd, din_of(16'hBEEF) & wmask(0));
    run_acc(2'd0, 1, 16'h1111, 32'h89AB_CDEF, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R6 8-bit write", dseen, 32'h0000_00EF);
    cfg_r0[29:28] = 2'd1;
    run_acc(2'd0, 0, 16'h4321, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R6 16-bit read", rd, din_of(16'h4321) & wmask(1));
    run_acc(2'd0, 1, 16'h2222, 32'h89AB_CDEF, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R6 16-bit write", dseen, 32'h0000_CDEF);

    // Wait handling on region 2: rs=1 rst=2 rh=1.
    cfg_r2 = mk_cfg(0, 1, 2, 1, 4'd1, 6'd2, 3'd1, 4'd1, 6'd2, 3'd1);
    pulse(2, 2'b11);
    run_acc(2'd2, 0, 16'h0310, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R7 inactive wait no stretch", 32'(nstb), 32'd3);

    mem_wait = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 rise masked off", {30'd0, irq_status}, 32'd0);
    chk("R11 irq low when masked", {31'd0, irq}, 32'd0);
    pulse(0, 2'b10);
    chk("R10 rise flag", {30'd0, irq_status}, 32'd2);
    chk("R11 irq from status", {31'd0, irq}, 32'd1);
    pulse(2, 2'b10);
    chk("R12 clear rise", {30'd0, irq_status}, 32'd0);

    pulse(0, 2'b01);
    max_wait = 8'd3;
    run_acc(2'd2, 0, 16'h0777, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R9 timeout strobe", 32'(nstb), 32'd6);
    chk("R9 timeout cycles no hold", 32'(ncyc), 32'((turn ? 2 : 0) + 2 + 6));
    chk("R9 timeout reported", {31'd0, tmo}, 32'd1);
    chk("R9 timeout data", rd, din_of(16'h0777));
    chk("R9 timeout flag", {30'd0, irq_status}, 32'd1);
    pulse(2, 2'b01);
    chk("R12 clear timeout", {30'd0, irq_status}, 32'd0);

    cfg_r2[30] = 1'b0;
    run_acc(2'd2, 0, 16'h0778, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R8 wait ignored strobe", 32'(nstb), 32'd3);
    chk("R8 wait ignored cycles", 32'(ncyc), 32'(2 + 3 + 2));
    chk("R8 no timeout", {31'd0, tmo}, 32'd0);
    chk("R8 no flag", {30'd0, irq_status}, 32'd0);

    cfg_r2[30] = 1'b1;
    max_wait = 8'd200;
    run_acc(2'd2, 0, 16'h0779, 0, 7, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R7 release ends strobe", 32'(nstb), 32'd9);
    chk("R7 release cycles", 32'(ncyc), 32'(2 + 9 + 2));
    chk("R7 release no timeout", {31'd0, tmo}, 32'd0);

    wait_pol = 1'b0;
    mem_wait = 1'b0;
    max_wait = 8'd0;
    repeat (4) @(negedge clk);
    run_acc(2'd2, 0, 16'h077A, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R7 active-low immediate timeout", 32'(nstb), 32'd3);
    chk("R9 zero limit cycles", 32'(ncyc), 32'(2 + 3));
    chk("R9 zero limit timeout", {31'd0, tmo}, 32'd1);
    mem_wait = 1'b1;
    repeat (4) @(negedge clk);
    run_acc(2'd2, 0, 16'h077B, 0, 0, ncyc, nstb, ncs, csseen, dseen, rd, tmo, turn);
    chk("R7 active-low released", 32'(nstb), 32'd3);
    chk("R7 active-low no timeout", {31'd0, tmo}, 32'd0);

    pulse(1, 2'b11);
    chk("R11 mask clear hides raw", {30'd0, irq_status}, 32'd0);
    pulse(0, 2'b11);
    chk("R11 mask set shows raw", {30'd0, irq_status}, 32'd3);
    pulse(2, 2'b11);
    chk("R12 clear both", {29'd0, irq, irq_status}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule